// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block maps a 32-bit physical address to one of four DRAM chip-select rows. Software programs four 8-bit boundary registers through a small write/read port. Each register holds address bits 31:24 of the exclusive top of its row, so rows are sized in 16 MB steps. The boundaries stack on each other: a row starts where the row below it ends, and row 0 starts at address zero.

The lookup is purely combinational. An incoming address gives a one-hot row select, a hit flag and an out-of-range flag. For every row the block also reports its base, its limit (both as address bits 31:24) and an empty flag.

A row whose boundary equals the one below it holds no memory and is never selected. A boundary that falls below the one before it makes that row empty. It also cuts off every later row, so none of them can be reached. Each row is expected to hold a module of 16 MB to 512 MB. The block does not enforce these sizes.

Top module: `row_bound_decoder`

## Requirements
- R1: Four 8-bit boundary registers are written on a rising clock edge when `regWrEn` is high. `regAddr` value i (0 to 3) selects row i's register. `regRdData` shows the register chosen by `regAddr` combinationally.
- R2: After reset all boundary registers read 0. Every row is then flagged empty, `rowSel` is 0 and every address is out of range.
- R3: Row i's limit is its boundary shifted to address bits 31:24, and the limit is exclusive. Row i's base is boundary i-1 at the same position, and row 0's base is 0. `rowLimit[8i+7:8i]` and `rowBase[8i+7:8i]` carry these bits 31:24.
- R4: A row whose boundary equals the previous boundary (0 for row 0) is flagged empty in `rowEmpty` and is never selected.
- R5: An address A selects row i when row i is not empty and base_i <= A < limit_i. `rowSel` bit i is then 1 and all its other bits are 0. `rowSel` never has more than one bit set.
- R6: A boundary lower than the previous boundary makes that row and every later row empty.
- R7: `outOfRange` is 1 exactly when A is at or above the top limit. The top limit is the boundary of the last row before any decrease (normally row 3), or 0 if that boundary is 0. When `outOfRange` is 1, `rowSel` is 0.
- R8: `rowHit` is 1 exactly when some `rowSel` bit is set, and it is always the opposite of `outOfRange`.
- R9: While `regWrEn` is low, the boundary registers keep their values whatever `regAddr` and `regWrData` carry.
- R10: Decoding uses only address bits 31:24. Addresses that differ only in bits 23:0 give the same row select and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Boundary register write enable |
| regAddr | input | 2 | Boundary register index (row number) |
| regWrData | input | 8 | Boundary write data (address bits 31:24) |
| regRdData | output | 8 | Boundary register selected by regAddr |
| lookupAddr | input | 32 | Physical address to decode |
| rowSel | output | 4 | One-hot selected row |
| rowHit | output | 1 | Address falls in some non-empty row |
| outOfRange | output | 1 | Address is at or above the top reachable limit |
| rowBase | output | 32 | Per-row base, bits 31:24, row i at [8i+7:8i] |
| rowLimit | output | 32 | Per-row exclusive limit, bits 31:24, row i at [8i+7:8i] |
| rowEmpty | output | 4 | Per-row empty flag |

## Verification
The registers are the only state in this block. A wrong register value shows up on `regRdData`, `rowBase` and `rowLimit` in the cycle after the write. It also shifts the lookup boundaries, so sweeping all 256 address pages exposes it at once. A faulty validity chain shows up as a row that is flagged empty but still selected, or as a decrease that fails to cut off the later rows. Both appear on `rowEmpty` and `rowSel` without delay. The sweep runs for several boundary patterns: ascending, repeated, decreasing, and all-maximum.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;
  localparam int ROWS    = 4;
  localparam int BOUND_W = 8;
  localparam int ADDR_W  = 32;
  localparam int IDX_W   = $clog2(ROWS);

  // control -> datapath write strobes
  typedef struct packed {
    logic [ROWS-1:0]    load;
    logic [BOUND_W-1:0] data;
  } wrStrobe_t;
endpackage

// File: rtl/rowdec_ctrl.sv
module rowdec_ctrl
  import rowdec_pkg::*;
(
  input  logic                          regWrEn,
  input  logic [IDX_W-1:0]              regAddr,
  input  logic [BOUND_W-1:0]            regWrData,
  input  logic [ROWS-1:0][BOUND_W-1:0]  bounds,
  output wrStrobe_t                     strobe,
  output logic [BOUND_W-1:0]            regRdData
);
  // Decode the register index into one load strobe per row (R1)
  always_comb begin
    strobe.data = regWrData;
    strobe.load = '0;
    if (regWrEn) strobe.load[regAddr] = 1'b1;
  end

  assign regRdData = bounds[regAddr];

  always_comb begin
    AST_LOAD_ONEHOT: assert ($onehot0(strobe.load)); // R1
  end
endmodule

// File: rtl/rowdec_dp.sv
module rowdec_dp
  import rowdec_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  wrStrobe_t                     strobe,
  input  logic [ADDR_W-1:0]             lookupAddr,
  output logic [ROWS-1:0][BOUND_W-1:0]  bounds,
  output logic [ROWS-1:0][BOUND_W-1:0]  prevBound,
  output logic [ROWS-1:0]               rowValid,
  output logic [ROWS-1:0]               rowSel,
  output logic                          rowHit,
  output logic                          outOfRange
);
  logic [BOUND_W-1:0] page;
  logic [ROWS:0]      okChain;
  logic [BOUND_W-1:0] topLimit;

  assign page = lookupAddr[ADDR_W-1 -: BOUND_W];

  // Boundary registers
  for (genvar gi = 0; gi < ROWS; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                bounds[gi] <= '0;
      else if (strobe.load[gi])  bounds[gi] <= strobe.data;
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.load[gi] |=> bounds[gi] == $past(strobe.data)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe.load[gi] |=> $stable(bounds[gi])); // R9
  end

  // Each row's base is the limit of the row below it
  assign prevBound[0] = '0;
  for (genvar gi = 1; gi < ROWS; gi++) begin : g_prev
    assign prevBound[gi] = bounds[gi-1];
  end

  // Validity chain: a decrease breaks it for all later rows
  always_comb begin
    okChain[0] = 1'b1;
    topLimit   = '0;
    for (int i = 0; i < ROWS; i++) begin
      okChain[i+1] = okChain[i] & (bounds[i] >= prevBound[i]);
      rowValid[i]  = okChain[i] & (bounds[i] > prevBound[i]);
      if (okChain[i+1]) topLimit = bounds[i];
    end
  end

  // Range compare per row
  for (genvar gi = 0; gi < ROWS; gi++) begin : g_sel
    assign rowSel[gi] = rowValid[gi] & (page >= prevBound[gi]) & (page < bounds[gi]);
  end

  assign rowHit     = |rowSel;
  assign outOfRange = (page >= topLimit);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rowSel)); // R5
  AST_OOR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    outOfRange |-> rowSel == '0); // R7
  AST_HIT_XOR_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    rowHit != outOfRange); // R8
endmodule

// File: rtl/row_bound_decoder.sv
module row_bound_decoder
  import rowdec_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      regWrEn,
  input  logic [IDX_W-1:0]          regAddr,
  input  logic [BOUND_W-1:0]        regWrData,
  output logic [BOUND_W-1:0]        regRdData,
  input  logic [ADDR_W-1:0]         lookupAddr,
  output logic [ROWS-1:0]           rowSel,
  output logic                      rowHit,
  output logic                      outOfRange,
  output logic [ROWS*BOUND_W-1:0]   rowBase,
  output logic [ROWS*BOUND_W-1:0]   rowLimit,
  output logic [ROWS-1:0]           rowEmpty
);
  wrStrobe_t                    strobe;
  logic [ROWS-1:0][BOUND_W-1:0] bounds;
  logic [ROWS-1:0][BOUND_W-1:0] prevBound;
  logic [ROWS-1:0]              rowValid;

  rowdec_ctrl u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .bounds    (bounds),
    .strobe    (strobe),
    .regRdData (regRdData)
  );

  rowdec_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .lookupAddr (lookupAddr),
    .bounds     (bounds),
    .prevBound  (prevBound),
    .rowValid   (rowValid),
    .rowSel     (rowSel),
    .rowHit     (rowHit),
    .outOfRange (outOfRange)
  );

  assign rowBase  = prevBound;
  assign rowLimit = bounds;
  assign rowEmpty = ~rowValid;
endmodule

// File: tb/test_row_bound_decoder.sv
module test_row_bound_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [31:0] lookupAddr = '0;
  logic [3:0]  rowSel;
  logic        rowHit, outOfRange;
  logic [31:0] rowBase, rowLimit;
  logic [3:0]  rowEmpty;

  int checks = 0;
  int errors = 0;
  logic [7:0] bnd [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  row_bound_decoder i_row_bound_decoder (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lookupAddr(lookupAddr),
    .rowSel(rowSel), .rowHit(rowHit), .outOfRange(outOfRange),
    .rowBase(rowBase), .rowLimit(rowLimit), .rowEmpty(rowEmpty)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeBound(input int idx, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = idx[1:0]; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
    bnd[idx] = val;
  endtask

  task automatic loadAll(input logic [7:0] b0, b1, b2, b3);
    writeBound(0, b0); writeBound(1, b1); writeBound(2, b2); writeBound(3, b3);
  endtask

  // Full sweep of the current configuration against an arithmetic model
  task automatic sweep(input string tag);
    logic [3:0]  expEmpty;
    logic [31:0] expBase, expLimit;
    logic [7:0]  prev, top;
    logic        broken;
    prev = 0; top = 0; broken = 0; expEmpty = 0; expBase = 0; expLimit = 0;
    for (int i = 0; i < 4; i++) begin
      expBase[8*i +: 8]  = prev;
      expLimit[8*i +: 8] = bnd[i];
      if (!broken && bnd[i] > prev) top = bnd[i];
      else expEmpty[i] = 1'b1;
      if (bnd[i] < prev) broken = 1'b1;
      prev = bnd[i];
    end
    check({tag, " R3 base"}, rowBase, expBase);
    check({tag, " R3 limit"}, rowLimit, expLimit);
    check({tag, " R4/R6 empty"}, {28'd0, rowEmpty}, {28'd0, expEmpty});
    for (int i = 0; i < 4; i++) begin
      regAddr = i[1:0];
      #1;
      check({tag, " R1 readback"}, {24'd0, regRdData}, {24'd0, bnd[i]});
    end
    for (int p = 0; p < 256; p++) begin
      logic [3:0] expSel;
      logic [23:0] low;
      expSel = 0;
      for (int i = 0; i < 4; i++) begin
        logic [7:0] base;
        base = (i == 0) ? 8'd0 : bnd[i-1];
        if (!expEmpty[i] && p >= base && p < bnd[i]) expSel[i] = 1'b1;
      end
      // R10: vary the low bits, only 31:24 matter
      low = (p[0]) ? 24'hFFFFFF : 24'(p * 24'h010203 ^ 24'h0ABCDE);
      lookupAddr = {p[7:0], low};
      #1;
      check({tag, " R5/R10 sel"}, {28'd0, rowSel}, {28'd0, expSel});
      check({tag, " R7 oor"}, {31'd0, outOfRange}, {31'd0, (p >= top)});
      check({tag, " R8 hit"}, {31'd0, rowHit}, {31'd0, (expSel != 0)});
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) bnd[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    check("R2 empty", {28'd0, rowEmpty}, 32'hF);
    lookupAddr = 32'h0000_0000; #1;
    check("R2 oor at 0", {31'd0, outOfRange}, 32'd1);
    check("R2 sel", {28'd0, rowSel}, 32'd0);
    sweep("reset R2");

    loadAll(8'h10, 8'h20, 8'h40, 8'h80);
    sweep("ascending");

    // R9: idle bus activity leaves registers alone
    @(negedge clk);
    regAddr = 2'd2; regWrData = 8'h77;
    repeat (2) @(negedge clk);
    check("R9 hold", {24'd0, regRdData}, 32'h40);

    loadAll(8'h00, 8'h20, 8'h20, 8'h40);
    sweep("equal rows R4");

    loadAll(8'h20, 8'h10, 8'h40, 8'h60);
    sweep("decrease R6");

    loadAll(8'h30, 8'h40, 8'h50, 8'h48);
    sweep("late decrease R6");

    loadAll(8'h01, 8'h02, 8'h03, 8'hFF);
    sweep("tiny rows");

    loadAll(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    sweep("all max");

    loadAll(8'h20, 8'h40, 8'h60, 8'h80);
    sweep("512MB rows");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule